// File: doc/BRIEF.md
# Four-Channel Event Counter with Shared Byte Queue

The block counts rising edges on several asynchronous event lines using one fast system clock. Every line is brought into the clock domain by a two-stage synchroniser, and a rising-edge detector turns each event into a single-cycle increment for that channel's counter. The counters are synchronous and share the system clock.

A start pulse clears the counters and begins a run. A stop pulse ends the run. The capture sequencer then copies every counter, one byte per cycle, into a single byte queue that all channels share. A slow processor drains the queue through a byte-wide register port. Its read strobe is asynchronous, so it is synchronised, and the end of each access pops exactly one byte. The processor can also read status registers that give the queue state, the run state, the fill level and per-channel saturation.

A capture is either written whole or not at all. If the queue lacks room for a full record, the record is discarded and a sticky drop flag is raised.

Top module: `ev_count_fifo`

## Requirements
- R1: After reset the queue is empty and fill level is 0. The flag register (address 1) reads 8'h01 and no run or capture is active.
- R2: While a run is active, each rising edge on `ev_in[i]` adds exactly one to counter i. An edge counts only if the line is high for at least one clock and then low for at least one clock.
- R3: A start pulse outside a capture clears all counters, all saturation bits and the drop flag, and begins a run. A start pulse during a run restarts counting from zero.
- R4: A stop pulse during a run, with room in the queue, appends one record of NUM_CH*CNT_W/8 bytes. The record holds channel 0 first and channel NUM_CH-1 last, each channel least significant byte first. With the defaults a record is 16 bytes.
- R5: If fewer free bytes remain than one record needs, a stop discards the whole capture. The fill level is left unchanged and bit 2 of the flag register is set.
- R6: A counter that reaches all-ones holds that value on further events. Bit i of the saturation register (address 2) is then set.
- R7: Address 0 shows the oldest queued byte. The falling end of a read strobe at address 0 removes exactly one byte. Reads of other addresses, and reads of an empty queue, remove nothing.
- R8: The flag register at address 1 has these bits: bit0 empty, bit1 full, bit2 capture dropped, bit3 run active, bit4 capture in progress. Addresses 3 and 4 give the fill level, low byte and high byte.
- R9: When a capture write and a processor pop fall in the same cycle, both take effect. The fill level reflects both, and byte order is preserved.
- R10: A start pulse during a capture is ignored. A stop pulse outside a run is ignored and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | NUM_CH | Asynchronous event lines, one per channel |
| start | input | 1 | Single-cycle pulse that clears the counters and begins a run |
| stop | input | 1 | Single-cycle pulse that ends the run and triggers the capture |
| rd_strb | input | 1 | Asynchronous processor read strobe, active high |
| rd_addr | input | 3 | Register select: 0 data, 1 flags, 2 saturation, 3 and 4 fill level |
| rd_data | output | 8 | Contents of the selected register |

## Verification
The capture sequencer pushes bytes on sixteen consecutive cycles. A processor pop can land in any of those cycles. The bench raises a data read and holds it, then ends it on the same clock that issues the stop. The synchronised falling edge therefore arrives while the record is being written. The bench then checks that the fill level equals the two records minus one popped byte. It reads the remaining bytes back and confirms that they continue the first record and then give the second record in order.

// File: rtl/ev_pkg.sv
package ev_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CAPT = 2'd2
    } ev_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/ev_sync_edge.sv
module ev_sync_edge #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    typedef struct packed {
        logic [2:0] sh;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.sh = {q.sh[1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse = ~q.sh[1] & q.sh[2];
        end else begin : g_rise
            assign pulse = q.sh[1] & ~q.sh[2];
        end
    endgenerate

    // R2 / R7: one detected edge never spans two cycles
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/ev_chan_counter.sv
module ev_chan_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             sat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sat;
    } ctr_t;

    ctr_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.cnt = '0;
            d.sat = 1'b0;
        end else if (inc) begin
            if (q.cnt == CNT_MAX) d.sat = 1'b1;
            else                  d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt = q.cnt;
    assign sat = q.sat;

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0) && !sat);

    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) && inc && !clr |=> (cnt == CNT_MAX) && sat);
endmodule

// File: rtl/ev_byte_fifo.sv
module ev_byte_fifo #(
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [7:0]                 wdata,
    input  logic                       pop,
    output logic [7:0]                 rdata,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       empty,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;
    localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] lvl;
    } ptr_t;

    ptr_t q, d;
    logic [7:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty   = (q.lvl == '0);
    assign full    = (q.lvl == LVL_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        d = q;
        if (do_push) d.wr = q.wr + 1'b1;
        if (do_pop)  d.rd = q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.lvl = q.lvl + 1'b1;
            2'b01:   d.lvl = q.lvl - 1'b1;
            default: d.lvl = q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= wdata;
    end

    assign rdata = mem[q.rd];
    assign level = q.lvl;

    assert_no_push_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop && !empty && !full |=> $stable(level));

    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !push |=> empty);
endmodule

// File: rtl/ev_count_fifo.sv
module ev_count_fifo
    import ev_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ev_in,
    input  logic              start,
    input  logic              stop,
    input  logic              rd_strb,
    input  logic [2:0]        rd_addr,
    output logic [7:0]        rd_data
);
    localparam int BPC = CNT_W / BYTE_W;
    localparam int REC = NUM_CH * BPC;
    localparam int IW  = (REC > 1) ? $clog2(REC) : 1;
    localparam int LW  = $clog2(DEPTH) + 1;
    localparam logic [LW-1:0] ROOM_LIM = LW'(DEPTH - REC);
    localparam logic [IW-1:0] IDX_LAST = IW'(REC - 1);

    typedef struct packed {
        ev_state_e     st;
        logic [IW-1:0] idx;
        logic          drop;
    } seq_t;

    seq_t q, d;

    logic [NUM_CH-1:0]       edge_v;
    logic [NUM_CH-1:0]       sat_v;
    logic [NUM_CH*CNT_W-1:0] all_cnt;
    logic                    clr, running, capturing, room;
    logic                    rd_end, pop, push;
    logic [7:0]              push_byte, head;
    logic [LW-1:0]           lvl;
    logic                    f_empty, f_full;
    logic [15:0]             lvl16;

    assign running   = (q.st == ST_RUN);
    assign capturing = (q.st == ST_CAPT);
    assign room      = (lvl <= ROOM_LIM);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            ev_sync_edge #(.FALLING(1'b0)) u_sync (
                .clk(clk), .rst_n(rst_n), .din(ev_in[i]), .pulse(edge_v[i])
            );
            ev_chan_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .clr(clr),
                .inc(edge_v[i] && running),
                .cnt(all_cnt[i*CNT_W +: CNT_W]), .sat(sat_v[i])
            );
        end
    endgenerate

    ev_sync_edge #(.FALLING(1'b1)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .din(rd_strb), .pulse(rd_end)
    );

    assign pop       = rd_end && (rd_addr == 3'd0);
    assign push      = capturing;
    assign push_byte = all_cnt[{q.idx, 3'b000} +: 8];

    ev_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_byte),
        .pop(pop), .rdata(head), .level(lvl), .empty(f_empty), .full(f_full)
    );

    always_comb begin
        d   = q;
        clr = 1'b0;
        unique case (q.st)
            ST_IDLE, ST_RUN: begin
                if (start) begin
                    clr    = 1'b1;
                    d.drop = 1'b0;
                    d.st   = ST_RUN;
                end else if (stop && q.st == ST_RUN) begin
                    d.idx = '0;
                    if (room) d.st = ST_CAPT;
                    else begin
                        d.st   = ST_IDLE;
                        d.drop = 1'b1;
                    end
                end
            end
            ST_CAPT: begin
                d.idx = q.idx + 1'b1;
                if (q.idx == IDX_LAST) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, idx: '0, drop: 1'b0};
        else        q <= d;
    end

    assign lvl16 = 16'(lvl);

    always_comb begin
        case (rd_addr)
            3'd0:    rd_data = head;
            3'd1:    rd_data = {3'b000, capturing, running, q.drop, f_full, f_empty};
            3'd2:    rd_data = 8'(sat_v);
            3'd3:    rd_data = lvl16[7:0];
            3'd4:    rd_data = lvl16[15:8];
            default: rd_data = 8'h00;
        endcase
    end

    assert_capture_begins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running && stop && !start && room |=> capturing);

    assert_drop_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        running && stop && !start && !room |=> q.drop && !capturing);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        capturing && start |=> !running);

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) && stop && !start |=> (q.st == ST_IDLE));
endmodule

// File: tb/tb_ev_count_fifo.sv
module tb_ev_count_fifo;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0] a_ev = '0;
    logic       a_start = 0, a_stop = 0, a_rd = 0;
    logic [2:0] a_addr = '0;
    logic [7:0] a_data;

    logic [3:0] b_ev = '0;
    logic       b_start = 0, b_stop = 0, b_rd = 0;
    logic [2:0] b_addr = '0;
    logic [7:0] b_data;

    int total = 0;
    int bad   = 0;

    ev_count_fifo dut (
        .clk(clk), .rst_n(rst_n), .ev_in(a_ev), .start(a_start), .stop(a_stop),
        .rd_strb(a_rd), .rd_addr(a_addr), .rd_data(a_data)
    );

    ev_count_fifo #(.NUM_CH(4), .CNT_W(8), .DEPTH(16)) dut_sat (
        .clk(clk), .rst_n(rst_n), .ev_in(b_ev), .start(b_start), .stop(b_stop),
        .rd_strb(b_rd), .rd_addr(b_addr), .rd_data(b_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_a(input logic [2:0] addr, output logic [7:0] v);
        @(negedge clk); a_addr = addr; a_rd = 1'b1;
        repeat (4) @(negedge clk);
        v = a_data; a_rd = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic rd_b(input logic [2:0] addr, output logic [7:0] v);
        @(negedge clk); b_addr = addr; b_rd = 1'b1;
        repeat (4) @(negedge clk);
        v = b_data; b_rd = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic ev_a(input logic [3:0] mask, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); a_ev = mask;
            repeat (2) @(negedge clk); a_ev = '0;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic start_a();
        @(negedge clk); a_start = 1'b1; @(negedge clk); a_start = 1'b0;
    endtask

    task automatic stop_a();
        @(negedge clk); a_stop = 1'b1; @(negedge clk); a_stop = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic level_a(output int lv);
        logic [7:0] lo, hi;
        rd_a(3'd3, lo);
        rd_a(3'd4, hi);
        lv = {hi, lo};
    endtask

    task automatic expect_record(input string req, input logic [31:0] c0, input logic [31:0] c1,
                                 input logic [31:0] c2, input logic [31:0] c3, input int first);
        logic [127:0] rec;
        logic [7:0]   v;
        rec = {c3, c2, c1, c0};
        for (int k = first; k < 16; k++) begin
            rd_a(3'd0, v);
            chk(req, v, rec[k*8 +: 8]);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        int lv;
        rd_a(3'd1, v);   chk("R1 flags", v, 8'h01);
        level_a(lv);     chk("R1 level", lv, 0);
        rd_a(3'd2, v);   chk("R1 sat", v, 8'h00);
    endtask

    task automatic t_count();
        logic [7:0] v;
        int lv;
        start_a();
        rd_a(3'd1, v);   chk("R8 run bit", v, 8'h09);
        ev_a(4'b1001, 3);
        ev_a(4'b1010, 1);
        ev_a(4'b1000, 1);
        ev_a(4'b1111, 1);
        stop_a();
        level_a(lv);     chk("R4 record length", lv, 16);
        rd_a(3'd1, v);   chk("R8 flags after capture", v, 8'h00);
        expect_record("R2 R4 record", 32'd4, 32'd2, 32'd1, 32'd6, 0);
        rd_a(3'd1, v);   chk("R7 drained", v, 8'h01);
    endtask

    task automatic t_multibyte();
        start_a();
        ev_a(4'b0100, 300);
        stop_a();
        expect_record("R2 multi-byte count", 32'd0, 32'd0, 32'd300, 32'd0, 0);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        int lv;
        @(negedge clk); a_stop = 1'b1; @(negedge clk); a_stop = 1'b0;
        repeat (20) @(negedge clk);
        level_a(lv);     chk("R10 stop while idle", lv, 0);
        rd_a(3'd0, v);
        level_a(lv);     chk("R7 pop on empty", lv, 0);
        rd_a(3'd1, v);   chk("R7 empty flag kept", v, 8'h01);
        start_a();
        ev_a(4'b0001, 1);
        stop_a();
        rd_a(3'd1, v);
        rd_a(3'd3, v);   chk("R7 status read pops nothing", v, 8'd16);
        expect_record("R7 record after status reads", 32'd1, 32'd0, 32'd0, 32'd0, 0);
    endtask

    task automatic t_start_in_capture();
        logic [7:0] v;
        start_a();
        ev_a(4'b0001, 2);
        @(negedge clk); a_stop = 1'b1;
        @(negedge clk); a_stop = 1'b0; a_start = 1'b1;
        @(negedge clk); a_start = 1'b0;
        repeat (20) @(negedge clk);
        rd_a(3'd1, v);   chk("R10 start during capture", v, 8'h00);
        expect_record("R10 record intact", 32'd2, 32'd0, 32'd0, 32'd0, 0);
    endtask

    task automatic t_restart();
        start_a();
        ev_a(4'b0001, 4);
        start_a();
        ev_a(4'b0001, 1);
        stop_a();
        expect_record("R3 restart clears", 32'd1, 32'd0, 32'd0, 32'd0, 0);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        int lv;
        start_a();
        ev_a(4'b0010, 2);
        stop_a();
        start_a();
        ev_a(4'b1000, 7);
        @(negedge clk); a_addr = 3'd0; a_rd = 1'b1;
        repeat (4) @(negedge clk);
        v = a_data;
        chk("R9 head before overlap", v, 8'd0);
        a_rd = 1'b0; a_stop = 1'b1;
        @(negedge clk); a_stop = 1'b0;
        repeat (25) @(negedge clk);
        level_a(lv);     chk("R9 level after overlap", lv, 31);
        expect_record("R9 first record tail", 32'd0, 32'd2, 32'd0, 32'd0, 1);
        expect_record("R9 second record", 32'd0, 32'd0, 32'd0, 32'd7, 0);
    endtask

    task automatic t_drop();
        logic [7:0] v;
        int lv;
        for (int r = 0; r < 16; r++) begin
            start_a();
            stop_a();
        end
        rd_a(3'd1, v);   chk("R8 full flag", v, 8'h02);
        start_a();
        ev_a(4'b0001, 1);
        stop_a();
        rd_a(3'd1, v);   chk("R5 drop flag", v, 8'h06);
        level_a(lv);     chk("R5 level unchanged", lv, 256);
        for (int k = 0; k < 256; k++) rd_a(3'd0, v);
        rd_a(3'd1, v);   chk("R5 drop sticky after drain", v, 8'h05);
        start_a();
        rd_a(3'd1, v);   chk("R3 start clears drop", v, 8'h09);
        stop_a();
        expect_record("R3 zero record", 32'd0, 32'd0, 32'd0, 32'd0, 0);
    endtask

    task automatic t_saturate();
        logic [7:0] v;
        @(negedge clk); b_start = 1'b1; @(negedge clk); b_start = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk); b_ev = (k < 5) ? 4'b0011 : 4'b0001;
            repeat (2) @(negedge clk); b_ev = '0;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd_b(3'd2, v);   chk("R6 sat bits", v, 8'h01);
        @(negedge clk); b_stop = 1'b1; @(negedge clk); b_stop = 1'b0;
        repeat (10) @(negedge clk);
        rd_b(3'd0, v);   chk("R6 saturated value", v, 8'hFF);
        rd_b(3'd0, v);   chk("R6 unsaturated channel", v, 8'd5);
        rd_b(3'd0, v);   chk("R6 byte 2", v, 8'd0);
        rd_b(3'd0, v);   chk("R6 byte 3", v, 8'd0);
        @(negedge clk); b_start = 1'b1; @(negedge clk); b_start = 1'b0;
        rd_b(3'd2, v);   chk("R3 start clears sat", v, 8'h00);
    endtask

    initial begin
        #(5.0 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_count();
        t_multibyte();
        t_ignored();
        t_start_in_capture();
        t_restart();
        t_collision();
        t_drop();
        t_saturate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule